// File: doc/BRIEF.md
# Tagged Target Receive Queue

This block buffers the bytes that the responder side of a two-wire serial bus controller receives from a bus controller. The bus-side logic delivers one byte per push strobe together with a 2-bit frame tag telling whether the byte opened a transaction, sat in the middle of it, or closed it. Because every stored entry carries its tag, software that drains the queue through a single read stream can rebuild where each transaction began and ended. It does not need a separate side channel for this.

A register-side read strobe pops the head entry. The read word is always valid: it shows the head entry, or an all-zero word (tag "empty") when nothing is stored. The block drives three level events: an entry is present, the queue is full, and the fill level has reached a programmable threshold. A push that finds no room is dropped and recorded in a sticky overflow flag. A write to the target FIFO control word can flush the receive queue. The same word carries a flush request for the neighbouring transmit queue, which this block passes on as a one-cycle pulse.

Top module: `tgt_rxq_top`

## Requirements
- R1: The read word carries the head entry's tag in bits 31:30 and its byte in bits 7:0, with bits 29:8 zero. Entries leave in the order they were accepted, and a pop strobe advances to the next entry at the following clock edge.
- R2: Tag codes are 0 = empty, 1 = transaction start, 2 = middle data byte, 3 = final byte. A pushed tag of 1, 2 or 3 is stored and read back unchanged. A push carrying tag 0 is ignored and the fill level does not change.
- R3: While the queue holds nothing, the read word is all zeros (tag 0, byte 0). A pop strobe in that state changes nothing, so a later push is the next entry read.
- R4: `rx_evt` is high exactly while at least one entry is stored. It goes low in the cycle that follows the clock edge at which the last entry is popped.
- R5: `full_evt` is high exactly while the queue holds DEPTH entries.
- R6: `thld_evt` is high exactly while `thld_level` is non-zero and the fill level is at least `thld_level`.
- R7: A push with a non-zero tag that finds the queue full, with no pop accepted in the same cycle, is discarded and sets `overflow`. `overflow` stays set until a receive flush. A push and a pop in the same cycle on a full queue both take effect.
- R8: A control write with bit 31 set empties the receive queue and clears `overflow`. Any push or pop in the same cycle is dropped.
- R9: A control write with bit 30 set raises `tx_flush` for exactly the next cycle. A control write with bit 30 clear leaves `tx_flush` low in the next cycle.
- R10: After synchronous active-low reset the queue is empty, every event output and `overflow` are low, and the read word is zero.
- R11: A push and a pop in the same cycle on a non-empty, non-full queue leave the fill level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_stb | input | 1 | Bus side delivers one byte |
| push_tag | input | 2 | Frame tag of the delivered byte |
| push_byte | input | 8 | Delivered byte |
| pop_stb | input | 1 | Register-side read consumes the head entry |
| ctrl_wr | input | 1 | Write strobe of the target FIFO control word |
| ctrl_wdata | input | 32 | Control word; bit 31 flushes receive, bit 30 flushes transmit |
| thld_level | input | $clog2(DEPTH+1) | Threshold fill level, 0 disables the event |
| rd_word | output | 32 | Head entry as a read word |
| rx_evt | output | 1 | At least one entry stored |
| full_evt | output | 1 | Queue full |
| thld_evt | output | 1 | Fill level at or above threshold |
| overflow | output | 1 | Sticky: a push was dropped |
| tx_flush | output | 1 | One-cycle transmit flush request |

## Verification
The bench builds the block with DEPTH set to 8, so `thld_level` is 4 bits wide. At that depth a few pushes reach the full state, overflow, push-and-pop at full, and the wrap of both pointers around the storage. Thresholds from 1 to 8 cover the whole range of `thld_level`, including equality with the depth. A long random phase mixes frames, empty pops, ignored tag-0 pushes and flushes that collide with pushes and pops. A reference queue model is compared against every output after every clock.

// File: rtl/tgt_rxq_pkg.sv
package tgt_rxq_pkg;
    // Frame tag carried with every byte
    typedef enum logic [1:0] {
        TAG_EMPTY = 2'd0,
        TAG_START = 2'd1,
        TAG_DATA  = 2'd2,
        TAG_END   = 2'd3
    } frame_tag_e;

    // One stored entry: tag plus byte
    typedef struct packed {
        frame_tag_e  tag;
        logic [7:0]  data;
    } rxq_entry_t;

    localparam int RD_TAG_MSB     = 31;
    localparam int RD_TAG_LSB     = 30;
    localparam int CTRL_RX_FLUSH  = 31;
    localparam int CTRL_TX_FLUSH  = 30;
endpackage

// File: rtl/tgt_rxq_store.sv
// Circular storage of tagged entries with read/write pointers and a fill
// counter. Assumes the caller only asserts do_push when room exists (or a
// pop happens in the same cycle) and do_pop only when not empty; clear wins.
module tgt_rxq_store
    import tgt_rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_push,
    input  logic             do_pop,
    input  logic             clear,
    input  rxq_entry_t       wr_entry,
    output rxq_entry_t       head,
    output logic [CW-1:0]    level
);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    rxq_entry_t    mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    // Write the incoming entry at the write pointer
    always_ff @(posedge clk) begin
        if (do_push && !clear) mem[wr_ptr] <= wr_entry;
    end

    // Advance pointers with wrap at DEPTH-1 and track the fill level
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // Present the head entry
    always_comb head = mem[rd_ptr];
endmodule

// File: rtl/tgt_rxq_events.sv
// Derives the level events from the fill counter. Assumes level never
// exceeds DEPTH; a threshold of zero disables the threshold event.
module tgt_rxq_events #(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] level,
    input  logic [CW-1:0] thld_level,
    output logic          rx_evt,
    output logic          full_evt,
    output logic          thld_evt
);
    // Compare the fill level against zero, depth and threshold
    always_comb begin
        rx_evt   = (level != '0);
        full_evt = (level == CW'(DEPTH));
        thld_evt = (thld_level != '0) && (level >= thld_level);
    end
endmodule

// File: rtl/tgt_rxq_top.sv
// Tagged receive queue for the responder side of a two-wire bus. Accepts
// bytes with frame tags from the bus side, serves them through a read word,
// raises level events, records dropped pushes, and decodes flush requests
// from the control word. Assumes one push and one pop at most per cycle.
module tgt_rxq_top
    import tgt_rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_stb,
    input  logic [1:0]    push_tag,
    input  logic [7:0]    push_byte,
    input  logic          pop_stb,
    input  logic          ctrl_wr,
    input  logic [31:0]   ctrl_wdata,
    input  logic [CW-1:0] thld_level,
    output logic [31:0]   rd_word,
    output logic          rx_evt,
    output logic          full_evt,
    output logic          thld_evt,
    output logic          overflow,
    output logic          tx_flush
);
    logic          flush_rx;
    logic          is_empty;
    logic          is_full;
    logic          tag_ok;
    logic          pop_ok;
    logic          push_ok;
    logic          push_drop;
    logic [CW-1:0] level;
    rxq_entry_t    head;
    rxq_entry_t    wr_entry;

    // Decode control write and acceptance of push and pop
    always_comb begin
        flush_rx  = ctrl_wr && ctrl_wdata[CTRL_RX_FLUSH];
        is_empty  = (level == '0);
        is_full   = (level == CW'(DEPTH));
        tag_ok    = (push_tag != TAG_EMPTY);
        pop_ok    = pop_stb && !is_empty && !flush_rx;
        push_ok   = push_stb && tag_ok && !flush_rx && (!is_full || pop_ok);
        push_drop = push_stb && tag_ok && !flush_rx && is_full && !pop_ok;
        wr_entry  = '{tag: frame_tag_e'(push_tag), data: push_byte};
    end

    tgt_rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .do_push  (push_ok),
        .do_pop   (pop_ok),
        .clear    (flush_rx),
        .wr_entry (wr_entry),
        .head     (head),
        .level    (level)
    );

    tgt_rxq_events #(.DEPTH(DEPTH)) u_events (
        .level      (level),
        .thld_level (thld_level),
        .rx_evt     (rx_evt),
        .full_evt   (full_evt),
        .thld_evt   (thld_evt)
    );

    // Sticky overflow, cleared only by a receive flush
    always_ff @(posedge clk) begin
        if (!rst_n || flush_rx) overflow <= 1'b0;
        else if (push_drop)     overflow <= 1'b1;
    end

    // One-cycle transmit flush request toward the neighbouring queue
    always_ff @(posedge clk) begin
        if (!rst_n) tx_flush <= 1'b0;
        else        tx_flush <= ctrl_wr && ctrl_wdata[CTRL_TX_FLUSH];
    end

    // Build the read word; all zeros when nothing is stored
    always_comb begin
        rd_word = '0;
        if (!is_empty) begin
            rd_word[RD_TAG_MSB:RD_TAG_LSB] = head.tag;
            rd_word[7:0]                   = head.data;
        end
    end
endmodule

// File: rtl/tgt_rxq_checker.sv
// Temporal checks on the ports of the tagged receive queue.
module tgt_rxq_checker #(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ctrl_wr,
    input logic [31:0]   ctrl_wdata,
    input logic          push_stb,
    input logic [1:0]    push_tag,
    input logic          pop_stb,
    input logic [31:0]   rd_word,
    input logic          rx_evt,
    input logic          full_evt,
    input logic          thld_evt,
    input logic          overflow,
    input logic          tx_flush
);
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_word[29:8] == '0); // R1
    AST_EMPTY_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_evt |-> rd_word == '0); // R3
    AST_VALID_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        rx_evt |-> rd_word[31:30] != 2'd0); // R2
    AST_FULL_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        full_evt |-> rx_evt); // R5
    AST_THLD_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        thld_evt |-> rx_evt); // R6
    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        full_evt && push_stb && push_tag != 2'd0 && !pop_stb && !ctrl_wr
        |=> overflow); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow && !(ctrl_wr && ctrl_wdata[31]) |=> overflow); // R7
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && ctrl_wdata[31] |=> !rx_evt && !overflow); // R8
    AST_TX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && ctrl_wdata[30] |=> tx_flush); // R9
    AST_TX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl_wr && ctrl_wdata[30]) |=> !tx_flush); // R9
endmodule

bind tgt_rxq_top tgt_rxq_checker #(.DEPTH(DEPTH)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .ctrl_wdata (ctrl_wdata),
    .push_stb   (push_stb),
    .push_tag   (push_tag),
    .pop_stb    (pop_stb),
    .rd_word    (rd_word),
    .rx_evt     (rx_evt),
    .full_evt   (full_evt),
    .thld_evt   (thld_evt),
    .overflow   (overflow),
    .tx_flush   (tx_flush)
);

// File: tb/tgt_rxq_top_test.sv
`timescale 1ns/1ps
module tgt_rxq_top_test;
    localparam int D  = 8;
    localparam int CW = $clog2(D + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_stb = 1'b0;
    logic [1:0]    push_tag = '0;
    logic [7:0]    push_byte = '0;
    logic          pop_stb = 1'b0;
    logic          ctrl_wr = 1'b0;
    logic [31:0]   ctrl_wdata = '0;
    logic [CW-1:0] thld_level = '0;
    logic [31:0]   rd_word;
    logic          rx_evt, full_evt, thld_evt, overflow, tx_flush;

    int checks = 0;
    int errors = 0;
    logic [9:0] q [$];
    logic m_ovf = 1'b0;
    logic m_txf = 1'b0;

    always #2.5 clk = ~clk;

    tgt_rxq_top #(.DEPTH(D)) uut (
        .clk(clk), .rst_n(rst_n), .push_stb(push_stb), .push_tag(push_tag),
        .push_byte(push_byte), .pop_stb(pop_stb), .ctrl_wr(ctrl_wr),
        .ctrl_wdata(ctrl_wdata), .thld_level(thld_level), .rd_word(rd_word),
        .rx_evt(rx_evt), .full_evt(full_evt), .thld_evt(thld_evt),
        .overflow(overflow), .tx_flush(tx_flush)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Compare every output with the reference model
    task automatic compare_all();
        logic [31:0] w;
        w = '0;
        if (q.size() > 0) begin
            w[31:30] = q[0][9:8];
            w[7:0]   = q[0][7:0];
        end
        chk("R1", "rd_word", rd_word, w);
        chk("R4", "rx_evt", 32'(rx_evt), 32'(q.size() > 0));
        chk("R5", "full_evt", 32'(full_evt), 32'(q.size() == D));
        chk("R6", "thld_evt", 32'(thld_evt),
            32'((thld_level != 0) && (q.size() >= int'(thld_level))));
        chk("R7", "overflow", 32'(overflow), 32'(m_ovf));
        chk("R9", "tx_flush", 32'(tx_flush), 32'(m_txf));
    endtask

    // Drive one cycle of stimulus, advance the model, then compare
    task automatic step(input logic ps, input logic [1:0] tg, input logic [7:0] db,
                        input logic pp, input logic cw, input logic [31:0] cd);
        logic fl, popped, acc;
        push_stb = ps; push_tag = tg; push_byte = db; pop_stb = pp;
        ctrl_wr = cw; ctrl_wdata = cd;
        fl = cw && cd[31];
        if (fl) begin
            q.delete();
            m_ovf = 1'b0;
        end else begin
            popped = pp && (q.size() > 0);
            acc = ps && (tg != 0) && ((q.size() < D) || popped);
            if (ps && (tg != 0) && !acc) m_ovf = 1'b1;
            if (popped) void'(q.pop_front());
            if (acc) q.push_back({tg, db});
        end
        m_txf = cw && cd[30];
        @(negedge clk);
        compare_all();
    endtask

    task automatic push1(input logic [1:0] tg, input logic [7:0] db);
        step(1'b1, tg, db, 1'b0, 1'b0, '0);
    endtask

    task automatic pop1();
        step(1'b0, 2'd0, 8'h00, 1'b1, 1'b0, '0);
    endtask

    task automatic idle();
        step(1'b0, 2'd0, 8'h00, 1'b0, 1'b0, '0);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", "reset rd_word", rd_word, 32'h0);
        chk("R10", "reset events", {29'b0, rx_evt, full_evt, thld_evt}, 32'h0);
        chk("R10", "reset overflow", 32'(overflow), 32'h0);
        rst_n = 1'b1;
        thld_level = 4'd3;
        idle();
        // R3: pop empty does nothing, next push is head
        pop1();
        chk("R3", "empty word", rd_word, 32'h0);
        // R1/R2: a frame start, data, end; tag 0 push ignored
        push1(2'd1, 8'hA0);
        push1(2'd0, 8'hEE);
        chk("R2", "tag0 ignored word", rd_word, 32'h4000_00A0);
        push1(2'd2, 8'hA1);
        push1(2'd3, 8'hA2);
        chk("R6", "thld at 3", 32'(thld_evt), 32'h1);
        pop1();
        chk("R1", "order second", rd_word, 32'h8000_00A1);
        pop1();
        pop1();
        // R4: deasserted right after last pop
        chk("R4", "rx_evt after last pop", 32'(rx_evt), 32'h0);
        // R5/R7: fill to full, overflow, push+pop at full
        for (int i = 0; i < D; i++) push1(2'd2, 8'(i + 8'h10));
        chk("R5", "full", 32'(full_evt), 32'h1);
        push1(2'd3, 8'hFF);
        chk("R7", "overflow set", 32'(overflow), 32'h1);
        step(1'b1, 2'd3, 8'h77, 1'b1, 1'b0, '0);
        chk("R7", "full after push+pop", 32'(full_evt), 32'h1);
        pop1();
        // R11: push+pop mid-level
        step(1'b1, 2'd1, 8'h55, 1'b1, 1'b0, '0);
        chk("R11", "level kept", 32'(full_evt), 32'h0);
        // R8: flush with concurrent push and pop; R9 tx flush pulse
        step(1'b1, 2'd1, 8'h66, 1'b1, 1'b1, 32'hC000_0000);
        chk("R8", "flushed", 32'(rx_evt), 32'h0);
        chk("R8", "ovf cleared", 32'(overflow), 32'h0);
        chk("R9", "tx pulse", 32'(tx_flush), 32'h1);
        idle();
        chk("R9", "tx pulse ends", 32'(tx_flush), 32'h0);
        // R6: thresholds across range
        for (int t = 0; t <= D; t++) begin
            thld_level = CW'(t);
            for (int k = 0; k < D; k++) push1(2'd2, 8'(k));
            for (int k = 0; k < D; k++) pop1();
        end
        // Random mix
        for (int n = 0; n < 6000; n++) begin
            logic [31:0] r;
            r = $urandom;
            if (n % 500 == 0) thld_level = CW'($urandom_range(0, D));
            step(r[0] | r[1], r[3:2], r[11:4], r[12] & r[13],
                 (r[20:16] == 5'd0), {r[21], r[22], 30'h0});
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule